// File: doc/BRIEF.md
# Memory-Mapped Serial Flash Read Window

This block lets a processor read serial flash parts as if they were ordinary memory. A bus master issues a read request with a byte address. The block decodes which flash device owns that address, runs a complete serial read transaction on a four-line I/O bus, and returns the result as one or more 32-bit words. Each device is reached through its own fixed-size window. The request address is an offset from the window base: device `k` owns offsets `k * 2**WIN_LG2` up to `(k+1) * 2**WIN_LG2 - 1`.

Software describes the transaction in a single 32-bit configuration word. That word sets the read opcode, the line mode (one, two or four lines, plus an expansion-bus mode in which the opcode also uses four lines), the number of dummy bytes, three- or four-byte addressing, and how many words one request returns. A lock bit freezes the configuration until the next reset. The serial clock runs at half the system clock. The configuration is captured when a request is accepted, so a later write does not disturb a transfer that is already running.

Top module: `flash_read_window`

## Requirements
- R1: After a synchronous reset, all selects are high, `spi_sck` is low, `bus_busy` and `bus_rvalid` are low, and `cfg_q` reads 0x00000003.
- R2: In the configuration word, bits 7:0 are the opcode, bits 9:8 the line mode, bits 13:12 the dummy byte count, bits 17:16 the address size (0 = three bytes, nonzero = four bytes, read back as 1), bits 25:24 the burst code and bit 31 the lock. `cfg_q` returns the stored fields with every other bit zero.
- R3: Once bit 31 is stored as 1, writes to the configuration word are ignored until reset.
- R4: The select index is `bus_addr[AW-1:WIN_LG2]`. During a transfer exactly that select is low, and the low `WIN_LG2` address bits form the offset.
- R5: The opcode goes out first, most significant bit first. It uses `spi_io_out[0]`, one bit per clock, except in mode 3, where it uses all four lines and the high nibble goes first.
- R6: The address follows the opcode, most significant bit first. Three-byte mode sends offset bits 23:0. Four-byte mode sends the offset zero-extended to 32 bits. Mode 0 uses line 0, mode 1 uses lines 1:0 (the higher bit on line 1), and modes 2 and 3 use lines 3:0.
- R7: Each dummy byte takes 8/lanes serial clocks between the address and the data. All output enables are low during these clocks.
- R8: Data is read from `spi_io_in[1]` in mode 0, from `spi_io_in[1:0]` in mode 1 and from `spi_io_in[3:0]` in modes 2 and 3. Each byte arrives most significant bit first, and the higher-numbered line carries the more significant bit. Every four bytes form a word with the first byte in bits 7:0.
- R9: Burst code b returns b+1 words (16 bytes for code 3), each flagged by a one-cycle `bus_rvalid`. `bus_rlast` marks the last word. In that same cycle the select is released and `bus_busy` is low.
- R10: A request that arrives while `bus_busy` is high is ignored.
- R11: `spi_sck` toggles only during a transfer and idles low. Outputs change when the clock falls, and inputs are sampled when it rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 32 | Configuration write value |
| cfg_q | output | 32 | Stored configuration |
| bus_req | input | 1 | One-cycle read request |
| bus_addr | input | AW | Byte offset from the window base |
| bus_busy | output | 1 | Transfer in progress |
| bus_rvalid | output | 1 | Read word valid |
| bus_rdata | output | 32 | Read word, little-endian |
| bus_rlast | output | 1 | Last word of the burst |
| spi_sck | output | 1 | Serial clock |
| spi_cs_n | output | CS_NUM | Active-low device selects |
| spi_io_out | output | 4 | Serial data out |
| spi_io_oe | output | 4 | Serial output enables |
| spi_io_in | input | 4 | Serial data in |

## Verification
The properties assume that reset is held from time zero and that `bus_req` is a single-cycle pulse. They do not assume that requests are spaced around `bus_busy`, so the ignored-request property sees real overlap. The stimulus writes only 0 or 1 into the address-size field, which keeps the read-back exact. The flash model in the bench derives its phase lengths from the configuration the bench has just written. Dummy-phase enables, opcode, address and cycle totals are all checked against that model, independently of the design.

// File: rtl/fw_pkg.sv
`timescale 1ns/1ps
package fw_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_CMD,
    PH_ADR,
    PH_DMY,
    PH_DAT
  } fw_ph_e;

  localparam logic [7:0] FW_RST_OP = 8'h03;

  // log2 of the lane count used by address, dummy and data phases
  function automatic logic [1:0] mode_lg(input logic [1:0] mode);
    logic [1:0] r;
    case (mode)
      2'd0:    r = 2'd0;
      2'd1:    r = 2'd1;
      default: r = 2'd2;
    endcase
    return r;
  endfunction

  // serial clocks in a phase minus one
  function automatic logic [7:0] span(input logic [7:0] bits, input logic [1:0] lg);
    return (bits >> lg) - 8'd1;
  endfunction

  function automatic logic [3:0] lane_mask(input logic [1:0] lg);
    logic [3:0] r;
    case (lg)
      2'd0:    r = 4'b0001;
      2'd1:    r = 4'b0011;
      default: r = 4'b1111;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/fw_cfg_reg.sv
`timescale 1ns/1ps
module fw_cfg_reg
  import fw_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        we,
  input  logic [31:0] wdata,
  output logic [7:0]  op,
  output logic [1:0]  mode,
  output logic [1:0]  dmy,
  output logic        addr4,
  output logic [1:0]  burst,
  output logic [31:0] q
);

  logic lock;
  logic unused_bits;

  assign unused_bits = ^{wdata[30:26], wdata[23:18], wdata[15:14], wdata[11:10]};

  always_ff @(posedge clk) begin
    if (rst) begin
      op    <= FW_RST_OP;
      mode  <= 2'd0;
      dmy   <= 2'd0;
      addr4 <= 1'b0;
      burst <= 2'd0;
      lock  <= 1'b0;
    end else if (we && !lock) begin
      op    <= wdata[7:0];
      mode  <= wdata[9:8];
      dmy   <= wdata[13:12];
      addr4 <= |wdata[17:16];
      burst <= wdata[25:24];
      lock  <= wdata[31];
    end
  end

  assign q = {lock, 5'd0, burst, 6'd0, 1'b0, addr4, 2'd0, dmy, 2'd0, mode, op};

endmodule

// File: rtl/fw_win_dec.sv
`timescale 1ns/1ps
module fw_win_dec #(
  parameter int CS_NUM  = 4,
  parameter int WIN_LG2 = 27,
  parameter int CSB     = 2,
  parameter int AW      = 29
) (
  input  logic [AW-1:0]     addr,
  output logic [CS_NUM-1:0] sel,
  output logic [31:0]       off32
);

  for (genvar g = 0; g < CS_NUM; g++) begin : g_sel
    assign sel[g] = (addr[AW-1:WIN_LG2] == CSB'(g));
  end

  assign off32 = 32'(addr[WIN_LG2-1:0]);

endmodule

// File: rtl/fw_shift_eng.sv
`timescale 1ns/1ps
module fw_shift_eng
  import fw_pkg::*;
#(
  parameter int CS_NUM = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [CS_NUM-1:0] sel,
  input  logic [31:0]       off32,
  input  logic [7:0]        op,
  input  logic [1:0]        mode,
  input  logic [1:0]        dmy,
  input  logic              addr4,
  input  logic [1:0]        burst,
  output logic              busy,
  output logic              sck,
  output logic [CS_NUM-1:0] cs_n,
  output logic [3:0]        io_out,
  output logic [3:0]        io_oe,
  input  logic [3:0]        io_in,
  output logic              rvalid,
  output logic [31:0]       rdata,
  output logic              rlast
);

  fw_ph_e            st;
  logic              sck_q;
  logic [CS_NUM-1:0] cs_q;
  logic [31:0]       sh, raw, off_q;
  logic [1:0]        lg_q, dlg_q, dmy_q, bst_q;
  logic              a4_q;
  logic [7:0]        cnt, wcnt;
  logic              rv_q, rl_q;
  logic [31:0]       rd_q;
  logic [7:0]        dat_bits;
  logic [1:0]        cmd_lg;

  function automatic logic [31:0] shl(input logic [31:0] v, input logic [1:0] lg);
    logic [31:0] r;
    case (lg)
      2'd0:    r = {v[30:0], 1'b0};
      2'd1:    r = {v[29:0], 2'b0};
      default: r = {v[27:0], 4'b0};
    endcase
    return r;
  endfunction

  function automatic logic [31:0] shin(input logic [31:0] v, input logic [3:0] d,
                                       input logic [1:0] lg);
    logic [31:0] r;
    case (lg)
      2'd0:    r = {v[30:0], d[1]};
      2'd1:    r = {v[29:0], d[1:0]};
      default: r = {v[27:0], d};
    endcase
    return r;
  endfunction

  assign dat_bits = ({6'd0, bst_q} + 8'd1) << 5;
  assign cmd_lg   = (mode == 2'd3) ? 2'd2 : 2'd0;

  always_ff @(posedge clk) begin
    if (rst) begin
      st    <= PH_IDLE;
      sck_q <= 1'b0;
      cs_q  <= '1;
      sh    <= '0;
      raw   <= '0;
      off_q <= '0;
      lg_q  <= 2'd0;
      dlg_q <= 2'd0;
      dmy_q <= 2'd0;
      bst_q <= 2'd0;
      a4_q  <= 1'b0;
      cnt   <= '0;
      wcnt  <= '0;
      rv_q  <= 1'b0;
      rl_q  <= 1'b0;
      rd_q  <= '0;
    end else begin
      rv_q <= 1'b0;
      rl_q <= 1'b0;
      if (st == PH_IDLE) begin
        if (start) begin
          cs_q  <= ~sel;
          sh    <= {op, 24'd0};
          lg_q  <= cmd_lg;
          cnt   <= span(8'd8, cmd_lg);
          dlg_q <= mode_lg(mode);
          dmy_q <= dmy;
          bst_q <= burst;
          a4_q  <= addr4;
          off_q <= off32;
          sck_q <= 1'b0;
          st    <= PH_CMD;
        end
      end else if (!sck_q) begin
        // rising serial edge: sample inputs
        sck_q <= 1'b1;
        if (st == PH_DAT) raw <= shin(raw, io_in, dlg_q);
      end else begin
        // falling serial edge: advance outputs and phases
        sck_q <= 1'b0;
        if (st == PH_DAT) begin
          if (wcnt == 8'd0) begin
            rv_q <= 1'b1;
            rd_q <= {raw[7:0], raw[15:8], raw[23:16], raw[31:24]};
            rl_q <= (cnt == 8'd0);
            wcnt <= span(8'd32, dlg_q);
          end else begin
            wcnt <= wcnt - 8'd1;
          end
        end
        if (cnt != 8'd0) begin
          cnt <= cnt - 8'd1;
          sh  <= shl(sh, lg_q);
        end else begin
          case (st)
            PH_CMD: begin
              st   <= PH_ADR;
              lg_q <= dlg_q;
              sh   <= a4_q ? off_q : {off_q[23:0], 8'd0};
              cnt  <= span(a4_q ? 8'd32 : 8'd24, dlg_q);
            end
            PH_ADR: begin
              if (dmy_q != 2'd0) begin
                st  <= PH_DMY;
                cnt <= span({3'd0, dmy_q, 3'd0}, dlg_q);
              end else begin
                st   <= PH_DAT;
                cnt  <= span(dat_bits, dlg_q);
                wcnt <= span(8'd32, dlg_q);
              end
            end
            PH_DMY: begin
              st   <= PH_DAT;
              cnt  <= span(dat_bits, dlg_q);
              wcnt <= span(8'd32, dlg_q);
            end
            default: begin
              st   <= PH_IDLE;
              cs_q <= '1;
            end
          endcase
        end
      end
    end
  end

  always_comb begin
    case (lg_q)
      2'd0:    io_out = {3'b000, sh[31]};
      2'd1:    io_out = {2'b00, sh[31:30]};
      default: io_out = sh[31:28];
    endcase
    io_oe = (st == PH_CMD || st == PH_ADR) ? lane_mask(lg_q) : 4'b0000;
  end

  assign busy   = (st != PH_IDLE);
  assign sck    = sck_q;
  assign cs_n   = cs_q;
  assign rvalid = rv_q;
  assign rdata  = rd_q;
  assign rlast  = rl_q;

endmodule

// File: rtl/flash_read_window.sv
`timescale 1ns/1ps
module flash_read_window
  import fw_pkg::*;
#(
  parameter  int CS_NUM  = 4,
  parameter  int WIN_LG2 = 27,
  localparam int CSB     = $clog2(CS_NUM),
  localparam int AW      = WIN_LG2 + CSB
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [31:0]       cfg_wdata,
  output logic [31:0]       cfg_q,
  input  logic              bus_req,
  input  logic [AW-1:0]     bus_addr,
  output logic              bus_busy,
  output logic              bus_rvalid,
  output logic [31:0]       bus_rdata,
  output logic              bus_rlast,
  output logic              spi_sck,
  output logic [CS_NUM-1:0] spi_cs_n,
  output logic [3:0]        spi_io_out,
  output logic [3:0]        spi_io_oe,
  input  logic [3:0]        spi_io_in
);

  logic [7:0]        c_op;
  logic [1:0]        c_mode, c_dmy, c_burst;
  logic              c_a4;
  logic [CS_NUM-1:0] sel;
  logic [31:0]       off32;

  fw_cfg_reg u_cfg (
    .clk   (clk),
    .rst   (rst),
    .we    (cfg_we),
    .wdata (cfg_wdata),
    .op    (c_op),
    .mode  (c_mode),
    .dmy   (c_dmy),
    .addr4 (c_a4),
    .burst (c_burst),
    .q     (cfg_q)
  );

  fw_win_dec #(
    .CS_NUM  (CS_NUM),
    .WIN_LG2 (WIN_LG2),
    .CSB     (CSB),
    .AW      (AW)
  ) u_dec (
    .addr  (bus_addr),
    .sel   (sel),
    .off32 (off32)
  );

  fw_shift_eng #(
    .CS_NUM (CS_NUM)
  ) u_eng (
    .clk    (clk),
    .rst    (rst),
    .start  (bus_req),
    .sel    (sel),
    .off32  (off32),
    .op     (c_op),
    .mode   (c_mode),
    .dmy    (c_dmy),
    .addr4  (c_a4),
    .burst  (c_burst),
    .busy   (bus_busy),
    .sck    (spi_sck),
    .cs_n   (spi_cs_n),
    .io_out (spi_io_out),
    .io_oe  (spi_io_oe),
    .io_in  (spi_io_in),
    .rvalid (bus_rvalid),
    .rdata  (bus_rdata),
    .rlast  (bus_rlast)
  );

endmodule

// File: rtl/flash_read_window_chk.sv
`timescale 1ns/1ps
module flash_read_window_chk #(
  parameter int CS_NUM = 4
) (
  input logic              clk,
  input logic              rst,
  input logic [31:0]       cfg_q,
  input logic              bus_req,
  input logic              bus_busy,
  input logic              bus_rvalid,
  input logic              bus_rlast,
  input logic              spi_sck,
  input logic [CS_NUM-1:0] spi_cs_n,
  input logic [3:0]        spi_io_oe
);

  assert_cs_onehot_R4: assert property (@(posedge clk) disable iff (rst)
    $onehot0(~spi_cs_n));

  assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (rst)
    !bus_busy |-> (&spi_cs_n && !spi_sck && spi_io_oe == 4'b0000));

  assert_sck_falls_R11: assert property (@(posedge clk) disable iff (rst)
    (bus_busy && spi_sck) |=> !spi_sck);

  assert_last_valid_R9: assert property (@(posedge clk) disable iff (rst)
    bus_rlast |-> (bus_rvalid && !bus_busy && &spi_cs_n));

  assert_lock_hold_R3: assert property (@(posedge clk) disable iff (rst)
    cfg_q[31] |=> $stable(cfg_q));

  assert_busy_ignore_R10: assert property (@(posedge clk) disable iff (rst)
    (bus_busy && bus_req) |=> ($stable(spi_cs_n) || &spi_cs_n));

endmodule

bind flash_read_window flash_read_window_chk #(.CS_NUM(CS_NUM)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .cfg_q      (cfg_q),
  .bus_req    (bus_req),
  .bus_busy   (bus_busy),
  .bus_rvalid (bus_rvalid),
  .bus_rlast  (bus_rlast),
  .spi_sck    (spi_sck),
  .spi_cs_n   (spi_cs_n),
  .spi_io_oe  (spi_io_oe)
);

// File: tb/flash_read_window_bench.sv
`timescale 1ns/1ps
module flash_read_window_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_q;
  logic        bus_req = 1'b0;
  logic [28:0] bus_addr = '0;
  logic        bus_busy, bus_rvalid, bus_rlast, spi_sck;
  logic [31:0] bus_rdata;
  logic [3:0]  spi_cs_n, spi_io_out, spi_io_oe;
  logic [3:0]  m_in = 4'b0000;

  int n_tot = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  flash_read_window u_flash_read_window (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .cfg_q(cfg_q),
    .bus_req(bus_req), .bus_addr(bus_addr), .bus_busy(bus_busy),
    .bus_rvalid(bus_rvalid), .bus_rdata(bus_rdata), .bus_rlast(bus_rlast),
    .spi_sck(spi_sck), .spi_cs_n(spi_cs_n), .spi_io_out(spi_io_out),
    .spi_io_oe(spi_io_oe), .spi_io_in(m_in)
  );

  // configuration the flash model follows
  logic [1:0] b_mode = 2'd0, b_dmy = 2'd0, b_bst = 2'd0;
  logic       b_a4 = 1'b0;

  function automatic logic [7:0] pat(input logic [31:0] a);
    return a[7:0] ^ a[15:8] ^ a[23:16] ^ 8'h3C;
  endfunction

  function automatic int lanes(input logic [1:0] m);
    return (m == 2'd0) ? 1 : (m == 2'd1) ? 2 : 4;
  endfunction

  function automatic logic [3:0] take(input logic [3:0] io, input int l);
    return (l == 1) ? {3'b000, io[0]} : (l == 2) ? {2'b00, io[1:0]} : io;
  endfunction

  // flash model: captures on rising sck, drives on falling sck (R11)
  int          m_cyc, m_cs, m_oe_bad, m_ccy, m_acy, m_pre, m_ld;
  logic [7:0]  m_op;
  logic [31:0] m_adr;
  wire         cs_act = ~&spi_cs_n;

  always @(posedge cs_act) begin
    m_cyc = 0; m_op = '0; m_adr = '0; m_oe_bad = 0; m_cs = -1;
    for (int i = 0; i < 4; i++) if (!spi_cs_n[i]) m_cs = i;
  end

  always_comb begin
    m_ld  = lanes(b_mode);
    m_ccy = (b_mode == 2'd3) ? 2 : 8;
    m_acy = (b_a4 ? 32 : 24) / m_ld;
    m_pre = m_ccy + m_acy + (int'(b_dmy) * 8) / m_ld;
  end

  always @(posedge spi_sck) begin
    if (m_cyc < m_ccy)
      m_op = 8'((m_op << ((b_mode == 2'd3) ? 4 : 1)) |
                8'(take(spi_io_out, (b_mode == 2'd3) ? 4 : 1)));
    else if (m_cyc < m_ccy + m_acy)
      m_adr = (m_adr << m_ld) | 32'(take(spi_io_out, m_ld));
    else if (m_cyc < m_pre && spi_io_oe != 4'b0000)
      m_oe_bad = m_oe_bad + 1;
    m_cyc = m_cyc + 1;
  end

  always @(negedge spi_sck) begin
    if (cs_act && m_cyc >= m_pre) begin
      int pos, bi, bo;
      logic [7:0] byt;
      logic [3:0] v;
      pos = (m_cyc - m_pre) * m_ld;
      bi  = pos / 8;
      bo  = pos % 8;
      byt = pat(m_adr + 32'(bi));
      v   = 4'((byt >> (8 - m_ld - bo)) & 8'((1 << m_ld) - 1));
      m_in <= (m_ld == 1) ? {2'b00, v[0], 1'b0} : v;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    n_tot++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr_cfg(input logic [31:0] v);
    @(negedge clk);
    cfg_we = 1'b1; cfg_wdata = v;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // stimulus: op, mode, dummy, addr4, burst, address, expected select
  localparam int NV = 8;
  localparam logic [45:0] VEC [NV] = '{
    {8'h03, 2'd0, 2'd0, 1'b0, 2'd0, 29'h0000104, 2'd0},
    {8'h3B, 2'd1, 2'd1, 1'b0, 2'd1, 29'h8000200, 2'd1},
    {8'h6B, 2'd2, 2'd1, 1'b0, 2'd3, 29'h10000010, 2'd2},
    {8'hEC, 2'd2, 2'd3, 1'b1, 2'd2, 29'h1F0ABCD0, 2'd3},
    {8'h0B, 2'd0, 2'd1, 1'b1, 2'd3, 29'h01234560, 2'd0},
    {8'h03, 2'd0, 2'd0, 1'b0, 2'd0, 29'h0F123450, 2'd1},
    {8'h0D, 2'd3, 2'd0, 1'b0, 2'd1, 29'h00000AA0, 2'd0},
    {8'hBB, 2'd1, 2'd2, 1'b1, 2'd0, 29'h18000004, 2'd3}
  };

  task automatic run(input logic [45:0] v, input bit inject);
    logic [7:0]  op;
    logic [28:0] ad;
    logic [31:0] cw, sent, exp;
    int          nw, exp_cyc;
    bit          done;
    op = v[45:38]; ad = v[30:2];
    cw = {7'd0, v[32:31], 7'd0, v[33], 2'd0, v[35:34], 2'd0, v[37:36], op};
    wr_cfg(cw);
    chk(cfg_q == cw, "R2 cfg readback", cfg_q, cw);
    b_mode = v[37:36]; b_dmy = v[35:34]; b_a4 = v[33]; b_bst = v[32:31];
    sent = b_a4 ? {5'd0, ad[26:0]} : {8'd0, ad[23:0]};
    @(negedge clk);
    bus_req = 1'b1; bus_addr = ad;
    @(negedge clk);
    bus_req = 1'b0;
    nw = 0; done = 0;
    for (int t = 0; t < 2000 && !done; t++) begin
      @(negedge clk);
      bus_req = 1'b0;
      if (inject && t == 30 && bus_busy) begin
        bus_req = 1'b1; bus_addr = ad ^ 29'h08000000;
      end
      if (bus_rvalid) begin
        exp = {pat(sent + 32'(4*nw+3)), pat(sent + 32'(4*nw+2)),
               pat(sent + 32'(4*nw+1)), pat(sent + 32'(4*nw))};
        // data position depends on dummy length too (R7)
        chk(bus_rdata == exp, "R8 data word", bus_rdata, exp);
        chk(bus_rlast == (nw == int'(b_bst)), "R9 last flag", 32'(bus_rlast), 32'(nw == int'(b_bst)));
        if (bus_rlast) begin
          chk(!bus_busy && &spi_cs_n, "R9 release", {bus_busy, spi_cs_n}, 32'h0F);
          done = 1;
        end
        nw++;
      end
    end
    chk(nw == int'(b_bst) + 1, "R9 word count", 32'(nw), 32'(int'(b_bst) + 1));
    chk(m_op == op, "R5 opcode", 32'(m_op), 32'(op));
    chk(m_adr == sent, "R6 address", m_adr, sent);
    chk(m_cs == int'(v[1:0]), "R4 select", 32'(m_cs), 32'(v[1:0]));
    exp_cyc = m_pre + (int'(b_bst) + 1) * 32 / m_ld;
    chk(m_cyc == exp_cyc, "R7 clock count", 32'(m_cyc), 32'(exp_cyc));
    chk(m_oe_bad == 0, "R7 dummy release", 32'(m_oe_bad), 32'd0);
    if (inject) begin
      bus_req = 1'b0;
      repeat (8) @(negedge clk);
      chk(!bus_busy && &spi_cs_n, "R10 ignored request", {bus_busy, spi_cs_n}, 32'h0F);
    end
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(&spi_cs_n && !spi_sck && !bus_busy && !bus_rvalid, "R1 idle outputs",
        {spi_cs_n, spi_sck, bus_busy, bus_rvalid}, 32'h78);
    chk(cfg_q == 32'h3, "R1 cfg reset", cfg_q, 32'h3);

    for (int i = 0; i < NV; i++) run(VEC[i], 1'b0);

    // request while busy (R10)
    run(VEC[3], 1'b1);

    // lock (R3)
    wr_cfg(32'h800000AB);
    chk(cfg_q == 32'h800000AB, "R3 lock set", cfg_q, 32'h800000AB);
    wr_cfg(32'h00000013);
    chk(cfg_q == 32'h800000AB, "R3 write ignored", cfg_q, 32'h800000AB);
    @(negedge clk); rst = 1'b1;
    repeat (2) @(negedge clk); rst = 1'b0;
    @(negedge clk);
    chk(cfg_q == 32'h3, "R1 lock cleared by reset", cfg_q, 32'h3);
    wr_cfg(32'h00000013);
    chk(cfg_q == 32'h13, "R3 writable after reset", cfg_q, 32'h13);

    $display("test done: total=%0d bad=%0d", n_tot, n_bad);
    $finish;
  end

  initial begin
    #2000000;
    n_tot++; n_bad++;
    $display("FAIL R9 watchdog act=hung exp=done");
    $display("test done: total=%0d bad=%0d", n_tot, n_bad);
    $finish;
  end

endmodule